// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional Access

This block sits between one processor core and a small word-addressed memory and lets software build atomic read-modify-write sequences without locking anything. The core issues a load-reserved request, which reads a word and arms a reservation on its address. It later issues a store-conditional request to the same address. The store takes effect only if nothing has touched that address in the meantime, and the block always reports whether it did. Software loops until the store succeeds.

The reservation is killed by four things: any write seen on the snoop input, from another agent, to the reserved address; a plain store from the local core to that address; an explicit clear input used on a context switch; and any store-conditional. Interference is detected by the fact of a write, not by its value. A location that another agent changed and then restored still fails the store-conditional. Only one address is held at a time.

The tracker is a two-state machine. RSV_IDLE means no reservation. RSV_HELD means one address is reserved. It has five transitions:
- ARM: RSV_IDLE to RSV_HELD, taken on a load-reserved.
- REARM: RSV_HELD to RSV_HELD with the new address, taken on a load-reserved.
- CONSUME: RSV_HELD to RSV_IDLE, taken on any store-conditional.
- KILL: RSV_HELD to RSV_IDLE, taken on a snoop hit or on a local plain store hit.
- FLUSH: to RSV_IDLE, taken on a clear.

Requests are encoded on `req_op` as follows: 0 = load, 1 = store, 2 = load-reserved, 3 = store-conditional.

Top module: `rsv_monitor`

## Requirements
- R1: After reset, no reservation is held, `rsp_valid` is 0 and every memory word reads 0.
- R2: A request accepted at one clock edge produces `rsp_valid`=1 at the next edge. A load returns the stored word. A store writes its data and reports `rsp_fail`=0. A cycle without a request gives `rsp_valid`=0.
- R3: A load-reserved (op 2) returns the current word and arms a reservation on its address.
- R4: A store-conditional (op 3) to the reserved address, with no interference, writes the word and reports `rsp_fail`=0 (success).
- R5: A store-conditional with no reservation, or to an address other than the reserved one, reports `rsp_fail`=1 and leaves memory unchanged.
- R6: A snoop write to the reserved address kills the reservation, whatever value was written. A snoop write to another address does not.
- R7: Asserting `rsv_clear` kills the reservation.
- R8: A new load-reserved replaces the held reservation with its own address.
- R9: A local plain store to the reserved address kills the reservation.
- R10: A snoop write and a store-conditional to the reserved address in the same cycle: the snoop wins, the store-conditional fails and memory is unchanged.
- R11: Every store-conditional clears the reservation, whether it succeeds or fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request strobe |
| req_op | input | 2 | 0 load, 1 store, 2 load-reserved, 3 store-conditional |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| snoop_valid | input | 1 | Another agent writes this cycle |
| snoop_addr | input | ADDR_W | Address of the snooped write |
| rsv_clear | input | 1 | Discard any reservation (context switch) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | DATA_W | Read data for load and load-reserved, else 0 |
| rsp_fail | output | 1 | Store-conditional status: 0 success, 1 failure |

## Verification
The assertions check on every cycle that:
- a snoop hit or a clear leaves the tracker idle;
- any store-conditional consumes the reservation;
- memory is never written by a store-conditional unless a reservation is held;
- each response follows its request;
- a failure flag only answers a store-conditional.

Only the bench's scenarios can show the full atomic sequences, where the status is observed together with read-back of memory. These cover a repeated store-conditional failing, a reservation replaced by a second load-reserved, a snoop colliding in the same cycle, and a reset discarding a live reservation.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LR    = 2'd2,
        OP_SC    = 2'd3
    } rsv_op_e;

    typedef enum logic {
        RSV_IDLE = 1'b0,
        RSV_HELD = 1'b1
    } rsv_state_e;
endpackage

// File: rtl/rsv_word_store.sv
module rsv_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    assign rdata = words[addr];
endmodule

// File: rtl/rsv_tracker.sv
module rsv_tracker
    import rsv_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_fire,
    input  logic              sc_fire,
    input  logic              st_fire,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              clr,
    output logic              held,
    output logic              sc_ok
);
    rsv_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              snoop_hit;
    logic              local_hit;

    assign snoop_hit = snoop_valid && (snoop_addr == addr_q);
    assign local_hit = st_fire && (req_addr == addr_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSV_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            RSV_IDLE: begin
                if (lr_fire && !clr) begin          // ARM
                    state_d = RSV_HELD;
                    addr_d  = req_addr;
                end
            end
            RSV_HELD: begin
                if (clr) begin                      // FLUSH
                    state_d = RSV_IDLE;
                end else if (lr_fire) begin         // REARM
                    addr_d  = req_addr;
                end else if (sc_fire) begin         // CONSUME
                    state_d = RSV_IDLE;
                end else if (snoop_hit || local_hit) begin  // KILL
                    state_d = RSV_IDLE;
                end
            end
            default: state_d = RSV_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        held  = (state_q == RSV_HELD);
        sc_ok = held && sc_fire && (req_addr == addr_q) && !snoop_hit && !clr;
    end

    a_r6_snoop_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RSV_HELD && snoop_hit && !lr_fire) |=> (state_q == RSV_IDLE));
    a_r7_clear_kills: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state_q == RSV_IDLE));
    a_r11_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_fire && !lr_fire) |=> (state_q == RSV_IDLE));
    a_r9_local_store_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RSV_HELD && local_hit && !lr_fire) |=> (state_q == RSV_IDLE));
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
    import rsv_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              rsv_clear,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_fail
);
    rsv_op_e           op;
    logic              lr_fire, sc_fire, st_fire, ld_fire;
    logic              held, sc_ok, mem_we;
    logic [DATA_W-1:0] mem_rd;

    assign op      = rsv_op_e'(req_op);
    assign ld_fire = req_valid && (op == OP_LOAD);
    assign st_fire = req_valid && (op == OP_STORE);
    assign lr_fire = req_valid && (op == OP_LR);
    assign sc_fire = req_valid && (op == OP_SC);
    assign mem_we  = st_fire || sc_ok;

    rsv_tracker #(.ADDR_W(ADDR_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .lr_fire    (lr_fire),
        .sc_fire    (sc_fire),
        .st_fire    (st_fire),
        .req_addr   (req_addr),
        .snoop_valid(snoop_valid),
        .snoop_addr (snoop_addr),
        .clr        (rsv_clear),
        .held       (held),
        .sc_ok      (sc_ok)
    );

    rsv_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .addr (req_addr),
        .wdata(req_wdata),
        .rdata(mem_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_fail  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (ld_fire || lr_fire) ? mem_rd : '0;
            rsp_fail  <= sc_fire && !sc_ok;
        end
    end

    a_r5_sc_write_needs_rsv: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_fire && mem_we) |-> held);
    a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r4_fail_only_for_sc: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fail |-> $past(sc_fire));
endmodule

// File: tb/rsv_monitor_test.sv
module rsv_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [1:0]  req_op;
    logic [3:0]  req_addr;
    logic [31:0] req_wdata;
    logic        snoop_valid;
    logic [3:0]  snoop_addr;
    logic        rsv_clear;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_fail;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    rsv_monitor uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .rsv_clear(rsv_clear), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_fail(rsp_fail)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [31:0] wd;
        logic        sv;
        logic [3:0]  sa;
        logic        clr;
        logic        ef;
        logic        ck;
        logic [31:0] erd;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VT [NV] = '{
        '{2'd2, 4'h3, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0},   // R3 arm a3
        '{2'd3, 4'h3, 32'h11, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 32'h0},   // R4 success
        '{2'd0, 4'h3, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h11},  // R2 R4 readback
        '{2'd3, 4'h3, 32'h22, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 32'h0},   // R11 consumed
        '{2'd0, 4'h3, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h11},  // R5 unchanged
        '{2'd3, 4'h5, 32'h7,  1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 32'h0},   // R5 no rsv
        '{2'd0, 4'h5, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0},   // R5 unchanged
        '{2'd2, 4'h3, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h11},  // R3 rearm a3
        '{2'd0, 4'h0, 32'h0,  1'b1, 4'h3, 1'b0, 1'b0, 1'b1, 32'h0},   // R6 snoop a3
        '{2'd3, 4'h3, 32'h33, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 32'h0},   // R6 fails
        '{2'd2, 4'h3, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h11},  // R3
        '{2'd0, 4'h1, 32'h0,  1'b1, 4'h4, 1'b0, 1'b0, 1'b1, 32'h0},   // R6 other addr
        '{2'd3, 4'h3, 32'h44, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 32'h0},   // R6 survives
        '{2'd2, 4'h3, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h44},  // R4 readback
        '{2'd0, 4'h0, 32'h0,  1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 32'h0},   // R7 clear
        '{2'd3, 4'h3, 32'h55, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 32'h0},   // R7 fails
        '{2'd2, 4'h2, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0},   // R8 arm a2
        '{2'd2, 4'h6, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0},   // R8 replace a6
        '{2'd3, 4'h2, 32'h9,  1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 32'h0},   // R8 old fails
        '{2'd2, 4'h6, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0},   // R8
        '{2'd3, 4'h6, 32'h66, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 32'h0},   // R8 new ok
        '{2'd2, 4'h7, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0},   // R9 arm a7
        '{2'd1, 4'h7, 32'h1,  1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 32'h0},   // R9 R2 store
        '{2'd3, 4'h7, 32'h2,  1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 32'h0},   // R9 fails
        '{2'd0, 4'h7, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h1},   // R9 readback
        '{2'd2, 4'h8, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0},   // R10 arm a8
        '{2'd3, 4'h8, 32'h5,  1'b1, 4'h8, 1'b0, 1'b1, 1'b0, 32'h0},   // R10 collide
        '{2'd0, 4'h8, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0},   // R10 unchanged
        '{2'd2, 4'h9, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0},   // R11 arm a9
        '{2'd3, 4'hA, 32'h3,  1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 32'h0},   // R11 R5 wrong addr
        '{2'd3, 4'h9, 32'h4,  1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 32'h0},   // R11 consumed
        '{2'd0, 4'hA, 32'h0,  1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 32'h0}    // R5 unchanged
    };

    task automatic idle_inputs();
        req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_wdata = '0;
        snoop_valid = 1'b0; snoop_addr = '0; rsv_clear = 1'b0;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, check the response at the next falling edge
    task automatic issue(input vec_t v, input string tag);
        req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_wdata = v.wd;
        snoop_valid = v.sv; snoop_addr = v.sa; rsv_clear = v.clr;
        @(negedge clk);
        idle_inputs();
        check({tag, " rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
        check({tag, " rsp_fail"}, {31'b0, rsp_fail}, {31'b0, v.ef});
        if (v.ck) check({tag, " rsp_rdata"}, rsp_rdata, v.erd);
    endtask

    function automatic vec_t mk(input logic [1:0] op, input logic [3:0] a,
                                input logic [31:0] wd, input logic ef,
                                input logic ck, input logic [31:0] erd);
        mk = '{op, a, wd, 1'b0, 4'h0, 1'b0, ef, ck, erd};
    endfunction

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
        issue(mk(2'd0, 4'hF, 32'h0, 1'b0, 1'b1, 32'h0), "R1 mem zero");
        issue(mk(2'd3, 4'h0, 32'hAB, 1'b1, 1'b0, 32'h0), "R1 no rsv");
        issue(mk(2'd0, 4'h0, 32'h0, 1'b0, 1'b1, 32'h0), "R1 unchanged");

        for (int i = 0; i < NV; i++) begin
            issue(VT[i], $sformatf("vec%0d", i));
        end

        // R2 idle cycle gives no response
        @(negedge clk);
        check("R2 idle rsp_valid", {31'b0, rsp_valid}, 32'd0);

        // R1 reset discards a live reservation and clears memory
        issue(mk(2'd2, 4'hB, 32'h0, 1'b0, 1'b1, 32'h0), "R1 arm");
        issue(mk(2'd1, 4'hC, 32'h77, 1'b0, 1'b0, 32'h0), "R1 store");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        issue(mk(2'd3, 4'hB, 32'h9, 1'b1, 1'b0, 32'h0), "R1 rsv gone");
        issue(mk(2'd0, 4'hC, 32'h0, 1'b0, 1'b1, 32'h0), "R1 mem cleared");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule